// File: doc/BRIEF.md
# Vector Predicate Compare and Masked Store Unit

This unit forms per-byte predicate masks from lane-wise comparisons of two vector operands. It holds them in a small predicate register file and merges them with bitwise logic. A masked store uses one of these predicates to emit a byte-enabled write of a vector line. Each predicate register holds one bit per byte of the vector. A comparison on 32-bit lanes copies its single result into all four bits of that lane. Comparisons are either equality or signed greater-than. The second operand may be replaced by a scalar broadcast into every lane, which makes threshold tests cheap (for example "every byte above 31" or "every word equal to zero").

One operation is presented per cycle with `op_valid`. The operation code selects between compare, combine and store. Compare and combine results land in the destination register at the clock edge that ends the operation's cycle. A store reads the selected predicate as it stands in that cycle. It presents the write on the memory outputs one cycle later: the data is `vec_a`, and the enables are the predicate or its inverse. A store whose enables would all be zero produces no write cycle. The memory leaves every byte whose enable is low untouched.

Top module: `vpq_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all predicate registers clear to zero and `mem_we` and `mem_be` go low.
- R2: A compare with `elem_word`=1 and `cmp_gt`=0 (op_kind 1) writes, for each 32-bit lane w, predicate bits 4w..4w+3 all to 1 when the lanes of the two operands are equal and all to 0 otherwise; the result appears in register `dst_sel` after the clock edge that ends the operation's cycle.
- R3: A compare with `elem_word`=0 and `cmp_gt`=1 sets bit i exactly when byte i of `vec_a`, read as a signed 8-bit value, is greater than byte i of the second operand, read as a signed value.
- R4: The remaining modes also work: byte equality (`elem_word`=0, `cmp_gt`=0) and signed 32-bit greater-than (`elem_word`=1, `cmp_gt`=1), the latter replicated over the four bits of each lane.
- R5: A combine (op_kind 2) writes the value P[src0] op P[src1] to P[dst_sel], where `comb_fn` 0 is AND, 1 is OR, and 2 or 3 is XOR.
- R6: With `comb_inv`=1, AND and OR use the bitwise inverse of P[src1].
- R7: With XOR, `comb_inv` has no effect on the result.
- R8: A store (op_kind 3) with `st_inv`=0 and P[src0] nonzero raises `mem_we` in the next cycle, with `mem_be` equal to P[src0] and `mem_wdata` equal to the `vec_a` of the store cycle; bytes whose enable is 0 keep their memory contents.
- R9: A store with `st_inv`=1 drives `mem_be` with the bitwise inverse of P[src0].
- R10: When the effective store mask is all zeros, `mem_we` and `mem_be` stay zero in the following cycle.
- R11: With `splat_en`=1 the second compare operand is `splat_val` copied into every 32-bit lane in word mode, or its low byte copied into every byte in byte mode; `vec_b` is then ignored.
- R12: Predicate registers change only through a valid compare or combine, and only the register at `dst_sel`; stores, op_kind 0 and `op_valid`=0 leave them all unchanged and produce no write on the memory outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 0 none, 1 compare, 2 combine, 3 store |
| elem_word | input | 1 | Compare lane size: 0 byte, 1 32-bit word |
| cmp_gt | input | 1 | Compare kind: 0 equal, 1 signed greater-than |
| splat_en | input | 1 | Use the broadcast scalar as second compare operand |
| splat_val | input | 32 | Scalar to broadcast |
| vec_a | input | VB*8 | First operand; store data |
| vec_b | input | VB*8 | Second compare operand |
| dst_sel | input | log2(NP) | Destination predicate register |
| src0_sel | input | log2(NP) | First predicate source; store mask source |
| src1_sel | input | log2(NP) | Second predicate source |
| comb_fn | input | 2 | Combine function: 0 AND, 1 OR, 2/3 XOR |
| comb_inv | input | 1 | Invert second predicate for AND/OR |
| st_inv | input | 1 | Store where the predicate bit is clear |
| pred_flat | output | NP*VB | All predicate registers, register r at bits r*VB upward |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | VB | Per-byte write enables |
| mem_wdata | output | VB*8 | Write data |

## Verification
The bench goes after the signed boundary: bytes above 127 must compare as negative, so an unsigned comparator would set bits for them against a threshold of 31. Word equality is exercised with lanes that differ in only one byte; a design that compared bytes individually would leave a partial nibble. The bench runs stores from an all-zero and an all-one predicate (inverted) to catch a design that strobes an empty write. It also checks XOR with the invert flag, which a design that inverted for every function would get wrong. Predicates are compared after every cycle, so a store or idle cycle that disturbed a register, or a write to the wrong index, shows at once.

// File: rtl/vpq_pkg.sv
package vpq_pkg;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_CMP   = 2'd1,
        OPK_COMB  = 2'd2,
        OPK_STORE = 2'd3
    } opk_e;

    typedef enum logic [1:0] {
        CF_AND  = 2'd0,
        CF_OR   = 2'd1,
        CF_XOR  = 2'd2,
        CF_XOR2 = 2'd3
    } cfn_e;

    typedef struct packed {
        logic word;
        logic gt;
    } cmp_mode_t;

    typedef struct packed {
        cfn_e fn;
        logic inv;
    } comb_ctl_t;

    localparam int LANE_BYTES = 4;

    function automatic logic is_xor(input cfn_e f);
        return (f == CF_XOR) || (f == CF_XOR2);
    endfunction

endpackage

// File: rtl/vpq_compare.sv
module vpq_compare
    import vpq_pkg::*;
#(
    parameter int VB = 16
) (
    input  logic [VB*8-1:0] op_a,
    input  logic [VB*8-1:0] op_b,
    input  cmp_mode_t       mode,
    output logic [VB-1:0]   mask
);
    localparam int NW = VB / LANE_BYTES;

    logic [VB-1:0] byte_res;
    logic [VB-1:0] word_res;

    for (genvar i = 0; i < VB; i++) begin : g_byte
        logic signed [7:0] xa, xb;
        assign xa = op_a[8*i +: 8];
        assign xb = op_b[8*i +: 8];
        assign byte_res[i] = mode.gt ? (xa > xb) : (xa == xb);
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic signed [31:0] wa, wb;
        logic               hit;
        assign wa  = op_a[32*w +: 32];
        assign wb  = op_b[32*w +: 32];
        assign hit = mode.gt ? (wa > wb) : (wa == wb);
        assign word_res[LANE_BYTES*w +: LANE_BYTES] = {LANE_BYTES{hit}};
    end

    assign mask = mode.word ? word_res : byte_res;

endmodule

// File: rtl/vpq_combine.sv
module vpq_combine
    import vpq_pkg::*;
#(
    parameter int VB = 16
) (
    input  logic [VB-1:0] pa,
    input  logic [VB-1:0] pb,
    input  comb_ctl_t     ctl,
    output logic [VB-1:0] res
);
    logic [VB-1:0] pb_eff;

    always_comb begin
        pb_eff = (ctl.inv && !is_xor(ctl.fn)) ? ~pb : pb;
        unique case (ctl.fn)
            CF_AND:  res = pa & pb_eff;
            CF_OR:   res = pa | pb_eff;
            default: res = pa ^ pb_eff;
        endcase
    end

endmodule

// File: rtl/vpq_predfile.sv
module vpq_predfile #(
    parameter int VB = 16,
    parameter int NP = 4,
    localparam int SW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [SW-1:0]          wr_sel,
    input  logic [VB-1:0]          wr_data,
    output logic [NP-1:0][VB-1:0]  pred_q
);
    for (genvar r = 0; r < NP; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                pred_q[r] <= '0;
            else if (wr_en && (wr_sel == SW'(r)))
                pred_q[r] <= wr_data;
        end
    end

    // R12
    pred_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pred_q));

endmodule

// File: rtl/vpq_unit.sv
module vpq_unit
    import vpq_pkg::*;
#(
    parameter int VB = 16,
    parameter int NP = 4,
    localparam int VW = VB * 8,
    localparam int SW = (NP > 1) ? $clog2(NP) : 1,
    localparam int NW = VB / LANE_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic             elem_word,
    input  logic             cmp_gt,
    input  logic             splat_en,
    input  logic [31:0]      splat_val,
    input  logic [VW-1:0]    vec_a,
    input  logic [VW-1:0]    vec_b,
    input  logic [SW-1:0]    dst_sel,
    input  logic [SW-1:0]    src0_sel,
    input  logic [SW-1:0]    src1_sel,
    input  logic [1:0]       comb_fn,
    input  logic             comb_inv,
    input  logic             st_inv,
    output logic [NP*VB-1:0] pred_flat,
    output logic             mem_we,
    output logic [VB-1:0]    mem_be,
    output logic [VW-1:0]    mem_wdata
);
    opk_e                 kind;
    cmp_mode_t            cmode;
    comb_ctl_t            cctl;
    logic [VW-1:0]        opnd_b;
    logic [VB-1:0]        cmp_mask;
    logic [VB-1:0]        comb_res;
    logic [NP-1:0][VB-1:0] pred_q;
    logic                 pw_en;
    logic [VB-1:0]        pw_data;
    logic [VB-1:0]        st_mask;
    logic                 st_go;

    assign kind       = opk_e'(op_kind);
    assign cmode.word = elem_word;
    assign cmode.gt   = cmp_gt;
    assign cctl.fn    = cfn_e'(comb_fn);
    assign cctl.inv   = comb_inv;

    // broadcast scalar: whole word per lane, or low byte per byte
    always_comb begin
        if (!splat_en)
            opnd_b = vec_b;
        else if (elem_word)
            opnd_b = {NW{splat_val}};
        else
            opnd_b = {VB{splat_val[7:0]}};
    end

    vpq_compare #(.VB(VB)) u_cmp (
        .op_a (vec_a),
        .op_b (opnd_b),
        .mode (cmode),
        .mask (cmp_mask)
    );

    vpq_combine #(.VB(VB)) u_comb (
        .pa  (pred_q[src0_sel]),
        .pb  (pred_q[src1_sel]),
        .ctl (cctl),
        .res (comb_res)
    );

    assign pw_en   = op_valid && ((kind == OPK_CMP) || (kind == OPK_COMB));
    assign pw_data = (kind == OPK_CMP) ? cmp_mask : comb_res;

    vpq_predfile #(.VB(VB), .NP(NP)) u_pf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pw_en),
        .wr_sel  (dst_sel),
        .wr_data (pw_data),
        .pred_q  (pred_q)
    );

    assign pred_flat = pred_q;

    // masked store stage
    assign st_mask = st_inv ? ~pred_q[src0_sel] : pred_q[src0_sel];
    assign st_go   = op_valid && (kind == OPK_STORE) && (|st_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else if (st_go) begin
            mem_we    <= 1'b1;
            mem_be    <= st_mask;
            mem_wdata <= vec_a;
        end else begin
            mem_we    <= 1'b0;
            mem_be    <= '0;
        end
    end

    // R10
    wr_needs_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_be != '0));

    // R12
    be_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we |-> (mem_be == '0));

    // R8
    we_from_store_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(op_valid && (op_kind == 2'd3)));

    // R2
    cmp_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (kind == OPK_CMP)) |=> (pred_q[$past(dst_sel)] == $past(cmp_mask)));

    for (genvar w = 0; w < NW; w++) begin : g_lane_chk
        // R2
        word_lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
            elem_word |-> ((cmp_mask[LANE_BYTES*w +: LANE_BYTES] == '0) ||
                           (cmp_mask[LANE_BYTES*w +: LANE_BYTES] == '1)));
    end

endmodule

// File: tb/vpq_unit_bench.sv
`timescale 1ns/1ps
module vpq_unit_bench;
    localparam int VB = 16;
    localparam int NP = 4;
    localparam int VW = VB * 8;
    localparam int SW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst;
    logic             op_valid;
    logic [1:0]       op_kind;
    logic             elem_word, cmp_gt, splat_en;
    logic [31:0]      splat_val;
    logic [VW-1:0]    vec_a, vec_b;
    logic [SW-1:0]    dst_sel, src0_sel, src1_sel;
    logic [1:0]       comb_fn;
    logic             comb_inv, st_inv;
    logic [NP*VB-1:0] pred_flat;
    logic             mem_we;
    logic [VB-1:0]    mem_be;
    logic [VW-1:0]    mem_wdata;

    vpq_unit #(.VB(VB), .NP(NP)) u_vpq_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .elem_word(elem_word), .cmp_gt(cmp_gt), .splat_en(splat_en),
        .splat_val(splat_val), .vec_a(vec_a), .vec_b(vec_b),
        .dst_sel(dst_sel), .src0_sel(src0_sel), .src1_sel(src1_sel),
        .comb_fn(comb_fn), .comb_inv(comb_inv), .st_inv(st_inv),
        .pred_flat(pred_flat), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [VB-1:0] m_pred [NP];
    logic          e_we;
    logic [VB-1:0] e_be;
    logic [VW-1:0] e_wd;

    function automatic logic [VB-1:0] ref_cmp(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                               input logic word, input logic gt);
        logic [VB-1:0] r = '0;
        if (!word) begin
            for (int i = 0; i < VB; i++) begin
                int x = $signed(a[8*i +: 8]);
                int y = $signed(b[8*i +: 8]);
                r[i] = gt ? (x > y) : (x == y);
            end
        end else begin
            for (int w = 0; w < VB/4; w++) begin
                longint x = $signed(a[32*w +: 32]);
                longint y = $signed(b[32*w +: 32]);
                logic h = gt ? (x > y) : (x == y);
                for (int k = 0; k < 4; k++) r[4*w+k] = h;
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] ref_opb();
        logic [VW-1:0] v = vec_b;
        if (splat_en)
            for (int i = 0; i < VB; i++)
                v[8*i +: 8] = elem_word ? splat_val[8*(i%4) +: 8] : splat_val[7:0];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [NP*VB-1:0] ep;
        for (int r = 0; r < NP; r++) ep[r*VB +: VB] = m_pred[r];
        chk(tag, VW'(pred_flat), VW'(ep), "predicates");
        chk(tag, VW'({mem_we, mem_be}), VW'({e_we, e_be}), "write strobe/enables");
        if (e_we) chk(tag, mem_wdata, e_wd, "write data");
    endtask

    // model one cycle from currently driven inputs, clock it, compare
    task automatic step(input string tag);
        logic [VB-1:0] nxt [NP];
        logic [VB-1:0] p1, msk;
        for (int r = 0; r < NP; r++) nxt[r] = m_pred[r];
        e_we = 1'b0; e_be = '0;
        if (op_valid) begin
            case (op_kind)
                2'd1: nxt[dst_sel] = ref_cmp(vec_a, ref_opb(), elem_word, cmp_gt);
                2'd2: begin
                    p1 = m_pred[src1_sel];
                    if (comb_fn == 2'd0) nxt[dst_sel] = m_pred[src0_sel] & (comb_inv ? ~p1 : p1);
                    else if (comb_fn == 2'd1) nxt[dst_sel] = m_pred[src0_sel] | (comb_inv ? ~p1 : p1);
                    else nxt[dst_sel] = m_pred[src0_sel] ^ p1;
                end
                2'd3: begin
                    msk = st_inv ? ~m_pred[src0_sel] : m_pred[src0_sel];
                    if (msk != '0) begin e_we = 1'b1; e_be = msk; e_wd = vec_a; end
                end
                default: ;
            endcase
        end
        @(posedge clk);
        #2;
        for (int r = 0; r < NP; r++) m_pred[r] = nxt[r];
        check_all(tag);
        @(negedge clk);
    endtask

    task automatic do_cmp(input logic [SW-1:0] d, input logic w, input logic g, input string tag);
        op_valid = 1; op_kind = 2'd1; dst_sel = d; elem_word = w; cmp_gt = g;
        step(tag);
    endtask

    task automatic do_comb(input logic [SW-1:0] d, input logic [SW-1:0] s0, input logic [SW-1:0] s1,
                           input logic [1:0] f, input logic inv, input string tag);
        op_valid = 1; op_kind = 2'd2; dst_sel = d; src0_sel = s0; src1_sel = s1;
        comb_fn = f; comb_inv = inv;
        step(tag);
    endtask

    task automatic do_store(input logic [SW-1:0] s0, input logic inv, input string tag);
        op_valid = 1; op_kind = 2'd3; src0_sel = s0; st_inv = inv;
        step(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        rst = 1; op_valid = 0; op_kind = 0; elem_word = 0; cmp_gt = 0; splat_en = 0;
        splat_val = 0; vec_a = '0; vec_b = '0; dst_sel = 0; src0_sel = 0; src1_sel = 0;
        comb_fn = 0; comb_inv = 0; st_inv = 0;
        for (int r = 0; r < NP; r++) m_pred[r] = '0;
        e_we = 0; e_be = '0; e_wd = '0;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check_all("R1");
        @(negedge clk);
        rst = 0;

        // R3 signed byte greater-than against splatted 31; bytes past 127 are negative
        for (int i = 0; i < VB; i++) vec_a[8*i +: 8] = 8'(i*9 + 20);
        splat_en = 1; splat_val = 32'd31;
        do_cmp(2'd0, 1'b0, 1'b1, "R3");
        // R11 byte splat uses only the low byte
        splat_val = 32'hAB00_0020;
        do_cmp(2'd1, 1'b0, 1'b1, "R11");

        // R2 word equality: lane 1 differs in one byte, lane 3 equal
        splat_en = 0;
        for (int i = 0; i < VB; i++) vec_b[8*i +: 8] = 8'(i*9 + 20);
        vec_b[8*5 +: 8] = 8'h00;
        do_cmp(2'd2, 1'b1, 1'b0, "R2");
        // R11 word splat of zero against vector with zero lanes
        vec_a[32 +: 32] = 32'h0; vec_a[96 +: 32] = 32'h0;
        vec_b = {VB{8'hFF}};
        splat_en = 1; splat_val = 32'h0;
        do_cmp(2'd3, 1'b1, 1'b0, "R11");
        splat_en = 0;

        // R4 byte equality and signed word greater-than
        vec_a = {VB{8'h5A}}; vec_b = {VB{8'h5A}};
        vec_b[8*3 +: 8] = 8'h11; vec_b[8*9 +: 8] = 8'h11;
        do_cmp(2'd3, 1'b0, 1'b0, "R4");
        vec_a = {32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF};
        vec_b = {32'h0000_0001, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFE};
        do_cmp(2'd1, 1'b1, 1'b1, "R4");

        // R5 / R6 / R7 combines
        do_comb(2'd2, 2'd0, 2'd3, 2'd0, 1'b0, "R5");
        do_comb(2'd2, 2'd0, 2'd3, 2'd1, 1'b0, "R5");
        do_comb(2'd2, 2'd0, 2'd3, 2'd2, 1'b0, "R5");
        do_comb(2'd2, 2'd0, 2'd3, 2'd0, 1'b1, "R6");
        do_comb(2'd2, 2'd0, 2'd3, 2'd1, 1'b1, "R6");
        do_comb(2'd2, 2'd0, 2'd3, 2'd2, 1'b1, "R7");
        do_comb(2'd2, 2'd0, 2'd3, 2'd3, 1'b1, "R7");

        // R8 / R9 stores
        for (int i = 0; i < VB; i++) vec_a[8*i +: 8] = 8'(8'hC0 + i);
        do_store(2'd0, 1'b0, "R8");
        vec_a = ~vec_a;
        do_store(2'd0, 1'b1, "R9");

        // R10 empty masks: all-zero predicate, and inverted all-ones predicate
        do_comb(2'd3, 2'd1, 2'd1, 2'd2, 1'b0, "R5");
        do_store(2'd3, 1'b0, "R10");
        do_comb(2'd3, 2'd3, 2'd3, 2'd1, 1'b1, "R6");
        do_store(2'd3, 1'b1, "R10");
        do_store(2'd3, 1'b0, "R8");

        // R12 idle cycles and op_kind 0 keep state and produce no write
        op_valid = 0; op_kind = 2'd1;
        step("R12");
        op_valid = 1; op_kind = 2'd0;
        step("R12");

        // mixed random stream
        for (int n = 0; n < 400; n++) begin
            string tg;
            for (int i = 0; i < VB/4; i++) begin
                vec_a[32*i +: 32] = $urandom;
                vec_b[32*i +: 32] = ($urandom_range(0, 2) == 0) ? vec_a[32*i +: 32] : $urandom;
            end
            op_valid = ($urandom_range(0, 7) != 0);
            op_kind = 2'($urandom_range(0, 3));
            elem_word = 1'($urandom); cmp_gt = 1'($urandom);
            splat_en = ($urandom_range(0, 3) == 0);
            splat_val = 32'($urandom_range(0, 63)) - 32'd16;
            dst_sel = 2'($urandom); src0_sel = 2'($urandom); src1_sel = 2'($urandom);
            comb_fn = 2'($urandom); comb_inv = 1'($urandom); st_inv = 1'($urandom);
            case (op_kind)
                2'd1: tg = elem_word ? "R4" : "R3";
                2'd2: tg = "R5";
                2'd3: tg = "R8";
                default: tg = "R12";
            endcase
            if (!op_valid) tg = "R12";
            step(tg);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule